// File: doc/BRIEF.md
# Multi-Channel Oscillator Divider Register Bank

This block is the memory-mapped settings store for a row of numerically controlled divider channels. Each channel owns a window of five 32-bit registers. The registers are control, base divisor, first increment, second increment and accumulator start value. The block decodes a small request/response bus and holds the programmed values. It drives each value onto that channel's flat output lanes for the divider core, and it returns register contents on reads. The number of channels is a parameter. Windows are spaced 0x4000 bytes apart, so channel `n` starts at byte address `n*0x4000`.

Software changes a channel in a fixed order. It clears the enable with a read-modify-write of the control register. It then writes the divisor, both increments and the accumulator start value, and finally restores the enable. The bank signals each enable rising edge to the core as a one-cycle load pulse, so that the core takes the accumulator start value at that moment.

The bus is valid/ready on both sides. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every accepted request, read or write, produces exactly one response beat. The response stays on `rsp_valid`/`rsp_rdata` without change until `rsp_ready` is high. While a response is held, `req_ready` is low, so the requester is stalled.

Top module: `nco_regbank`

## Requirements
- R1: After reset every register of every channel reads zero, all `ch_en` bits are low, no load pulse is issued and `rsp_valid` is low.
- R2: A byte address is split into window index `addr[ADDR_W-1:14]` and offset `addr[13:0]`. Offsets 0, 4, 8, 12 and 16 select control, divisor, increment 1, increment 2 and accumulator start value, in that order.
- R3: All 32 control bits are stored and read back as written. Control bit 31 drives the channel's `ch_en` lane.
- R4: The divisor register keeps bits [12:0] (fine part [1:0], coarse part [12:2]) and drives them on `ch_div`. Bits [31:13] read as zero.
- R5: Increment 1, increment 2 and the accumulator start value keep all 32 bits, read back as written, and appear on `ch_inc1`, `ch_inc2` and `ch_acc_init`.
- R6: A read of an offset other than the five listed, including unaligned ones, returns zero. A read of any window whose index is at or above `NCH` also returns zero. A write to any such address changes no register.
- R7: `ch_acc_load` for a channel is high for exactly one cycle, in the first cycle that its `ch_en` is high after being low. It does not pulse when control is rewritten with the enable already set, or when the enable is cleared.
- R8: Each accepted request yields one response beat in the next cycle, with read data for reads and zero for writes. A response that is not taken holds `rsp_valid` and `rsp_rdata` steady, and `req_ready` stays low until it is taken.
- R9: A write to one channel's window leaves every other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| ch_en | output | NCH | Per-channel enable |
| ch_div | output | NCH*13 | Per-channel divisor, 13 bits each |
| ch_inc1 | output | NCH*32 | Per-channel first increment |
| ch_inc2 | output | NCH*32 | Per-channel second increment |
| ch_acc_init | output | NCH*32 | Per-channel accumulator start value |
| ch_acc_load | output | NCH | One-cycle load pulse on enable rising edge |

## Verification
Some properties are checked by assertions on every cycle. The held response must stay stable, and each accepted request must be followed by a response. At most one window may be hit at a time. A channel's registers and outputs must not move unless a write is decoded to that channel or to the bank. The load pulse must never last longer than one cycle. The bench sweeps every register of every channel, plus windows and offsets outside the map. Only these scenarios show the actual addressing, the readback masking, that a held response carries the right data, and that load pulses come only on true enable rises and carry the right start value.

// File: rtl/nco_rb_pkg.sv
package nco_rb_pkg;
  localparam int WORD_W   = 32;
  localparam int DIV_W    = 13;
  localparam int OFF_W    = 14;
  localparam int EN_BIT   = 31;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_DIV  = 3'd1,
    SEL_INC1 = 3'd2,
    SEL_INC2 = 3'd3,
    SEL_ACC  = 3'd4,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/nco_rb_decode.sv
module nco_rb_decode
  import nco_rb_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    hit,
  output reg_sel_e          sel
);
  localparam int IDX_W = ADDR_W - OFF_W;

  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;

  assign idx = addr[ADDR_W-1:OFF_W];
  assign off = addr[OFF_W-1:0];

  always_comb begin
    case (off)
      14'd0:   sel = SEL_CTRL;
      14'd4:   sel = SEL_DIV;
      14'd8:   sel = SEL_INC1;
      14'd12:  sel = SEL_INC2;
      14'd16:  sel = SEL_ACC;
      default: sel = SEL_NONE;
    endcase
  end

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit[i] = (int'(idx) == i) && (sel != SEL_NONE);
  end
endmodule

// File: rtl/nco_rb_channel.sv
module nco_rb_channel
  import nco_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              en,
  output logic [DIV_W-1:0]  div,
  output logic [WORD_W-1:0] inc1,
  output logic [WORD_W-1:0] inc2,
  output logic [WORD_W-1:0] acc_init,
  output logic              acc_load
);
  logic [WORD_W-1:0] ctrl_q, inc1_q, inc2_q, acc_q;
  logic [DIV_W-1:0]  div_q;
  logic              en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      inc1_q <= '0;
      inc2_q <= '0;
      acc_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= ctrl_q[EN_BIT];
      if (wr_en) begin
        case (sel)
          SEL_CTRL: ctrl_q <= wdata;
          SEL_DIV:  div_q  <= wdata[DIV_W-1:0];
          SEL_INC1: inc1_q <= wdata;
          SEL_INC2: inc2_q <= wdata;
          SEL_ACC:  acc_q  <= wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rdata = ctrl_q;
      SEL_DIV:  rdata = {{(WORD_W-DIV_W){1'b0}}, div_q};
      SEL_INC1: rdata = inc1_q;
      SEL_INC2: rdata = inc2_q;
      SEL_ACC:  rdata = acc_q;
      default:  rdata = '0;
    endcase
  end

  assign en       = ctrl_q[EN_BIT];
  assign div      = div_q;
  assign inc1     = inc1_q;
  assign inc2     = inc2_q;
  assign acc_init = acc_q;
  assign acc_load = ctrl_q[EN_BIT] & ~en_q;

  // R7
  load_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load |=> !acc_load);

  // R9
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({ctrl_q, div_q, inc1_q, inc2_q, acc_q}));
endmodule

// File: rtl/nco_rb_rsp.sv
module nco_rb_rsp
  import nco_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              is_write,
  input  logic [WORD_W-1:0] rd_in,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              req_ready
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= is_write ? '0 : rd_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R8
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
endmodule

// File: rtl/nco_regbank.sv
module nco_regbank
  import nco_rb_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [WORD_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [WORD_W-1:0]     rsp_rdata,
  output logic [NCH-1:0]        ch_en,
  output logic [NCH*DIV_W-1:0]  ch_div,
  output logic [NCH*WORD_W-1:0] ch_inc1,
  output logic [NCH*WORD_W-1:0] ch_inc2,
  output logic [NCH*WORD_W-1:0] ch_acc_init,
  output logic [NCH-1:0]        ch_acc_load
);
  logic [NCH-1:0]    hit;
  reg_sel_e          sel;
  logic              fire;
  logic [WORD_W-1:0] ch_rd [NCH];
  logic [WORD_W-1:0] rd_mux;

  assign fire = req_valid && req_ready;

  nco_rb_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) decode_i (
    .addr (req_addr),
    .hit  (hit),
    .sel  (sel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    nco_rb_channel chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fire && req_write && hit[i]),
      .sel      (sel),
      .wdata    (req_wdata),
      .rdata    (ch_rd[i]),
      .en       (ch_en[i]),
      .div      (ch_div[i*DIV_W +: DIV_W]),
      .inc1     (ch_inc1[i*WORD_W +: WORD_W]),
      .inc2     (ch_inc2[i*WORD_W +: WORD_W]),
      .acc_init (ch_acc_init[i*WORD_W +: WORD_W]),
      .acc_load (ch_acc_load[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hit[i]) rd_mux = rd_mux | ch_rd[i];
    end
  end

  nco_rb_rsp rsp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .is_write  (req_write),
    .rd_in     (rd_mux),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .req_ready (req_ready)
  );

  // R2
  one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R6
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && (hit == '0)) |=>
      $stable({ch_en, ch_div, ch_inc1, ch_inc2, ch_acc_init}));
endmodule

// File: tb/nco_regbank_tb_top.sv
module nco_regbank_tb_top;
  localparam int NCH    = 4;
  localparam int ADDR_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NCH-1:0] ch_en, ch_acc_load;
  logic [NCH*13-1:0] ch_div;
  logic [NCH*32-1:0] ch_inc1, ch_inc2, ch_acc_init;

  int checks = 0;
  int fails = 0;
  int load_cnt [NCH];
  logic [31:0] load_val [NCH];
  logic [31:0] model [NCH][5];

  always #10 clk = ~clk;

  nco_regbank #(.NCH(NCH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ch_en(ch_en), .ch_div(ch_div), .ch_inc1(ch_inc1), .ch_inc2(ch_inc2),
    .ch_acc_init(ch_acc_init), .ch_acc_load(ch_acc_load)
  );

  initial begin
    for (int i = 0; i < NCH; i++) begin
      load_cnt[i] = 0;
      load_val[i] = '0;
    end
  end

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (ch_acc_load[i]) begin
        load_cnt[i] = load_cnt[i] + 1;
        load_val[i] = ch_acc_init[i*32 +: 32];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [ADDR_W-1:0] a,
                      input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    q = rsp_rdata;
    if (!rsp_valid) chk("R8", {31'b0, rsp_valid}, 32'd1);
  endtask

  function automatic logic [ADDR_W-1:0] adr(input int ch, input int off);
    return ADDR_W'(ch * 32'h4000 + off);
  endfunction

  function automatic logic [31:0] pat(input int ch, input int r);
    logic [31:0] v;
    v = 32'h5A3C_0000 ^ (ch << 20) ^ (r << 12) ^ (32'h0000_1F5B + r * 32'h111);
    if (r == 0) v[31] = ch[0];
    return v;
  endfunction

  function automatic logic [31:0] mask(input int r, input logic [31:0] v);
    return (r == 1) ? (v & 32'h0000_1FFF) : v;
  endfunction

  task automatic check_outputs(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk(req, {31'b0, ch_en[c]}, {31'b0, model[c][0][31]});
      chk(req, {19'b0, ch_div[c*13 +: 13]}, model[c][1]);
      chk(req, ch_inc1[c*32 +: 32], model[c][2]);
      chk(req, ch_inc2[c*32 +: 32], model[c][3]);
      chk(req, ch_acc_init[c*32 +: 32], model[c][4]);
    end
  endtask

  task automatic readback_all(input string req);
    logic [31:0] q;
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 5; r++) begin
        xfer(1'b0, adr(c, r * 4), '0, q);
        chk(req, q, model[c][r]);
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] q;
    int base;
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 5; r++) model[c][r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", {31'b0, rsp_valid}, 32'd0);
    chk("R1", {{(32-NCH){1'b0}}, ch_en}, 32'd0);
    check_outputs("R1");
    readback_all("R1");
    for (int c = 0; c < NCH; c++) chk("R1", load_cnt[c], 32'd0);

    // R2 R3 R4 R5 R9: sweep writes, channel by channel
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < 5; r++) begin
        xfer(1'b1, adr(c, r * 4), pat(c, r), q);
        chk("R8", q, 32'd0);
        model[c][r] = mask(r, pat(c, r));
      end
      check_outputs("R9");
    end
    readback_all("R2");
    check_outputs("R5");
    // R7: odd channels enabled by the first control write, acc value then zero
    for (int c = 0; c < NCH; c++) begin
      chk("R7", load_cnt[c], c % 2);
      if (c % 2 == 1) chk("R7", load_val[c], 32'd0);
    end

    // R4: upper divisor bits read zero even when written as ones
    xfer(1'b1, adr(2, 4), 32'hFFFF_FFFF, q);
    model[2][1] = 32'h0000_1FFF;
    xfer(1'b0, adr(2, 4), '0, q);
    chk("R4", q, 32'h0000_1FFF);

    // R6: unmapped offsets and windows
    for (int w = 0; w <= NCH + 1; w++) begin
      foreach (model[0][k]) begin end
      for (int o = 0; o < 4; o++) begin
        int off;
        off = (o == 0) ? 20 : (o == 1) ? 2 : (o == 2) ? 32'h3FFC : 17;
        xfer(1'b1, adr(w, off), 32'hFFFF_FFFF, q);
        xfer(1'b0, adr(w, off), '0, q);
        chk("R6", q, 32'd0);
      end
    end
    for (int w = NCH; w < NCH + 2; w++)
      for (int r = 0; r < 5; r++) begin
        xfer(1'b1, adr(w, r * 4), 32'hDEAD_BEEF, q);
        xfer(1'b0, adr(w, r * 4), '0, q);
        chk("R6", q, 32'd0);
      end
    xfer(1'b1, adr(63, 0), 32'h8000_0001, q);
    xfer(1'b0, adr(63, 0), '0, q);
    chk("R6", q, 32'd0);
    readback_all("R6");
    check_outputs("R6");

    // R3 R7: read-modify-write reprogramming sequence on channel 1
    base = load_cnt[1];
    xfer(1'b0, adr(1, 0), '0, q);
    xfer(1'b1, adr(1, 0), q & 32'h7FFF_FFFF, q);
    model[1][0] = model[1][0] & 32'h7FFF_FFFF;
    @(negedge clk);
    chk("R3", {31'b0, ch_en[1]}, 32'd0);
    chk("R7", load_cnt[1], base);
    xfer(1'b1, adr(1, 4), 32'h0000_0A0B, q); model[1][1] = 32'h0000_0A0B;
    xfer(1'b1, adr(1, 8), 32'h1234_5678, q); model[1][2] = 32'h1234_5678;
    xfer(1'b1, adr(1, 12), 32'h9ABC_DEF0, q); model[1][3] = 32'h9ABC_DEF0;
    xfer(1'b1, adr(1, 16), 32'h8000_0000, q); model[1][4] = 32'h8000_0000;
    xfer(1'b0, adr(1, 0), '0, q);
    xfer(1'b1, adr(1, 0), q | 32'h8000_0000, q);
    model[1][0] = model[1][0] | 32'h8000_0000;
    @(negedge clk);
    chk("R7", load_cnt[1], base + 1);
    chk("R7", load_val[1], 32'h8000_0000);
    // rewrite with enable kept high: no new pulse
    xfer(1'b1, adr(1, 0), model[1][0] ^ 32'h0000_00F0, q);
    model[1][0] = model[1][0] ^ 32'h0000_00F0;
    repeat (2) @(negedge clk);
    chk("R7", load_cnt[1], base + 1);
    check_outputs("R3");
    readback_all("R3");

    // R8: back-pressure on the response
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = adr(3, 8);
    @(posedge clk);
    @(negedge clk);
    req_addr = adr(0, 8);
    for (int k = 0; k < 3; k++) begin
      chk("R8", {31'b0, rsp_valid}, 32'd1);
      chk("R8", {31'b0, req_ready}, 32'd0);
      chk("R8", rsp_rdata, model[3][2]);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", {31'b0, rsp_valid}, 32'd1);
    chk("R8", rsp_rdata, model[0][2]);
    @(negedge clk);
    chk("R8", {31'b0, rsp_valid}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule